// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

This block provides three free-running interval timers for a small audio coprocessor. A single-cycle `base_tick` strobe marks each period of the 1.024 MHz time base. Every channel divides that strobe by a fixed ratio (128 for the two slow channels, 16 for the fast one). It then counts the divided steps against an 8-bit period value held per channel. Each completed period bumps a 4-bit event counter.

Software reaches the timers through a byte-wide register port. Writes set the period registers and clear counters. Reads fetch a counter value and clear it in the same access, so the CPU sees how many periods have elapsed since its last look. A separate enable vector, driven by a control register elsewhere, starts and stops each channel. There are no interrupts: the CPU polls.

Top module: `tri_interval_timer`

## Requirements
- R1: After a synchronous reset, every event counter, stage counter, prescaler and period register is zero, and `rdata` is zero.
- R2: While enabled, channels 0 and 1 advance their stage counter once per 128 `base_tick` strobes. Channel 2 advances once per 16 strobes. Strobes arriving while a channel is disabled are not counted.
- R3: The period registers of channels 0, 1 and 2 are written at addresses 0xFA, 0xFB and 0xFC. A stored value of 0 acts as a period of 256.
- R4: When a stage advance brings the stage count up to the period, the stage count returns to 0 and the 4-bit event counter increments modulo 16.
- R5: A read (`rd_en`) of address 0xFD, 0xFE or 0xFF places the event counter of channel 0, 1 or 2 on `rdata[3:0]` one cycle later, with `rdata[7:4]` zero, and clears that counter. A read of any other address returns 0.
- R6: A write to 0xFD, 0xFE or 0xFF clears the event counter of that channel, whatever the write data.
- R7: A 0-to-1 change of a channel's enable bit clears its prescaler, stage counter and event counter. The first stage advance then comes a full prescale interval after the enable.
- R8: A disabled channel holds its event counter and its stage position unchanged, except when a counter access clears the event counter.
- R9: A period write that carries a new value governs every following comparison. If the stage count already lies at or beyond the new period, the next stage advance wraps the stage count and increments the event counter. A write of the value already held changes nothing.
- R10: When a counter read falls on the same cycle as an increment of that counter, the read returns the value before the increment, and the counter ends at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | One-cycle strobe per 1.024 MHz base period |
| chan_en | input | 3 | Per-channel enable, bit i enables channel i |
| addr | input | 8 | Register address |
| wdata | input | 8 | Register write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data, valid the cycle after `rd_en` |

## Verification
Internal state reaches the ports only through the event counters, so a corrupted prescaler or stage count surfaces late. The fault shows only once a full period has elapsed, which can take up to 32768 strobes on a slow channel with period 256. A counter read then reports a value off by one or more. The tests therefore pick tick counts just short of and just past each period boundary. A wrongly kept or wrongly dropped counter shows at the next read, one cycle after the strobe. A lost restart on enable shows as a stray count within one prescale interval.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  // Divider ratio for a channel: the last channel runs fast, the others slow.
  function automatic int chan_div(input int idx, input int n_ch,
                                  input int slow, input int fast);
    return (idx == n_ch - 1) ? fast : slow;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic step
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] div_q;
  logic          at_end;

  assign at_end = (div_q == PW'(DIV - 1));
  assign step   = run && at_end;

  always_ff @(posedge clk) begin
    if (rst || restart)
      div_q <= '0;
    else if (run)
      div_q <= at_end ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel #(
  parameter int PER_W = 8,
  parameter int CNT_W = 4,
  parameter int DIV   = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             per_wr,
  input  logic [PER_W-1:0] per_data,
  input  logic             cnt_clr,
  output logic [CNT_W-1:0] cnt
);
  logic             en_q;
  logic             rise;
  logic             run;
  logic             step;
  logic             wrap;
  logic [PER_W-1:0] period_q;
  logic [PER_W-1:0] stage_q;
  logic [PER_W:0]   period_eff;
  logic [PER_W:0]   stage_nxt;
  logic [CNT_W-1:0] cnt_q;

  assign rise = en && !en_q;
  assign run  = en && !rise && tick;

  tmr_prescaler #(.DIV(DIV)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (rise),
    .run     (run),
    .step    (step)
  );

  // A zero period selects the full 2**PER_W range.
  assign period_eff = {(period_q == '0), period_q};
  assign stage_nxt  = {1'b0, stage_q} + 1'b1;
  assign wrap       = step && (stage_nxt >= period_eff);

  always_ff @(posedge clk) begin
    if (rst)
      en_q <= 1'b0;
    else
      en_q <= en;
  end

  always_ff @(posedge clk) begin
    if (rst)
      period_q <= '0;
    else if (per_wr && (per_data != period_q))
      period_q <= per_data;
  end

  always_ff @(posedge clk) begin
    if (rst || rise)
      stage_q <= '0;
    else if (step)
      stage_q <= wrap ? '0 : stage_nxt[PER_W-1:0];
  end

  // Clear outranks a coincident increment.
  always_ff @(posedge clk) begin
    if (rst || rise)
      cnt_q <= '0;
    else if (cnt_clr)
      cnt_q <= '0;
    else if (wrap)
      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_regif.sv
`timescale 1ns/1ps
module tmr_regif #(
  parameter int NUM_CH   = 3,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 4,
  parameter int PER_BASE = 'hFA,
  parameter int CNT_BASE = 'hFD
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all,
  output logic [NUM_CH-1:0]             per_wr,
  output logic [NUM_CH-1:0]             cnt_clr,
  output logic [DATA_W-1:0]             rdata
);
  logic [NUM_CH-1:0] cnt_hit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] PA = ADDR_W'(PER_BASE + i);
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(CNT_BASE + i);
    assign per_wr[i]  = wr_en && (addr == PA);
    assign cnt_hit[i] = (addr == CA);
    assign cnt_clr[i] = (wr_en || rd_en) && cnt_hit[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= '0;
      for (int i = 0; i < NUM_CH; i++)
        if (cnt_hit[i])
          rdata <= DATA_W'(cnt_all[i]);
    end
  end
endmodule

// File: rtl/tri_interval_timer.sv
`timescale 1ns/1ps
module tri_interval_timer #(
  parameter int NUM_CH   = 3,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int PER_W    = 8,
  parameter int CNT_W    = 4,
  parameter int SLOW_DIV = 128,
  parameter int FAST_DIV = 16,
  parameter int PER_BASE = 'hFA,
  parameter int CNT_BASE = 'hFD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_tick,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata
);
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CH-1:0]            per_wr;
  logic [NUM_CH-1:0]            cnt_clr;

  tmr_regif #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .PER_BASE(PER_BASE), .CNT_BASE(CNT_BASE)
  ) u_regif (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .cnt_all (cnt_all),
    .per_wr  (per_wr),
    .cnt_clr (cnt_clr),
    .rdata   (rdata)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int DIV = tmr_pkg::chan_div(i, NUM_CH, SLOW_DIV, FAST_DIV);
    tmr_channel #(.PER_W(PER_W), .CNT_W(CNT_W), .DIV(DIV)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .en       (chan_en[i]),
      .tick     (base_tick),
      .per_wr   (per_wr[i]),
      .per_data (wdata[PER_W-1:0]),
      .cnt_clr  (cnt_clr[i]),
      .cnt      (cnt_all[i])
    );
  end
endmodule

// File: rtl/tri_interval_timer_chk.sv
`timescale 1ns/1ps
module tri_interval_timer_chk #(
  parameter int NUM_CH   = 3,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 4,
  parameter int CNT_BASE = 'hFD
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_CH-1:0]            chan_en,
  input logic [ADDR_W-1:0]            addr,
  input logic                         wr_en,
  input logic                         rd_en,
  input logic [DATA_W-1:0]            rdata,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_all
);
  // R5
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rdata[DATA_W-1:CNT_W] == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(CNT_BASE + i);

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && addr == CA) |=> (cnt_all[i] == '0));

    // R6
    write_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == CA) |=> (cnt_all[i] == '0));

    // R7
    enable_restart_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(chan_en[i]) |=> (cnt_all[i] == '0));

    // R8
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
      (!chan_en[i] && !((rd_en || wr_en) && addr == CA)) |=> $stable(cnt_all[i]));

    // R4
    step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_all[i] != $past(cnt_all[i])) |->
        (cnt_all[i] == '0 || cnt_all[i] == CNT_W'($past(cnt_all[i]) + 1'b1)));
  end
endmodule

bind tri_interval_timer tri_interval_timer_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CNT_W(CNT_W), .CNT_BASE(CNT_BASE)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .chan_en (chan_en),
  .addr    (addr),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .rdata   (rdata),
  .cnt_all (cnt_all)
);

// File: tb/tri_interval_timer_tb.sv
`timescale 1ns/1ps
module tri_interval_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       base_tick = 1'b0;
  logic [2:0] chan_en = '0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tri_interval_timer u_dut (
    .clk(clk), .rst(rst), .base_tick(base_tick), .chan_en(chan_en),
    .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); base_tick = 1'b1;
      repeat (n) @(negedge clk);
      base_tick = 1'b0;
    end
  endtask

  task automatic set_en(input logic [2:0] m);
    @(negedge clk); chan_en = m;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 rdata after reset", rdata, 8'd0);
    rd(8'hFD, v); check("R1 counter0 reset", v, 8'd0);
    rd(8'hFE, v); check("R1 counter1 reset", v, 8'd0);
    rd(8'hFF, v); check("R1 counter2 reset", v, 8'd0);
  endtask

  task automatic t_fast;
    logic [7:0] v;
    set_en(3'b000); wr(8'hFC, 8'd3); set_en(3'b100);
    ticks(16 * 3 * 5);
    rd(8'hFF, v); check("R2 R4 fast channel count", v, 8'd5);
    rd(8'hFF, v); check("R5 clear on read", v, 8'd0);
    rd(8'hFA, v); check("R5 non-counter read", v, 8'd0);
  endtask

  task automatic t_slow;
    logic [7:0] v;
    set_en(3'b000); wr(8'hFA, 8'd1); wr(8'hFB, 8'd2); set_en(3'b011);
    ticks(128 * 3);
    rd(8'hFD, v); check("R2 slow channel0", v, 8'd3);
    rd(8'hFE, v); check("R2 R3 slow channel1", v, 8'd1);
    rd(8'hFF, v); check("R8 disabled channel2 idle", v, 8'd0);
    set_en(3'b000);
  endtask

  task automatic t_zero_period;
    logic [7:0] v;
    wr(8'hFC, 8'd0); set_en(3'b100);
    ticks(16 * 256 - 1);
    rd(8'hFF, v); check("R3 period0 just short", v, 8'd0);
    ticks(1);
    rd(8'hFF, v); check("R3 period0 as 256", v, 8'd1);
    set_en(3'b000);
  endtask

  task automatic t_wrap;
    logic [7:0] v;
    wr(8'hFC, 8'd1); set_en(3'b100);
    ticks(16 * 17);
    rd(8'hFF, v); check("R4 modulo 16 wrap", v, 8'd1);
    set_en(3'b000);
  endtask

  task automatic t_enable;
    logic [7:0] v;
    wr(8'hFC, 8'd1); set_en(3'b100);
    ticks(48);
    set_en(3'b000);
    ticks(100);
    rd(8'hFF, v); check("R8 hold while disabled", v, 8'd3);
    set_en(3'b100);
    ticks(40);
    set_en(3'b000); set_en(3'b100);
    rd(8'hFF, v); check("R7 counter cleared on enable", v, 8'd0);
    ticks(8);
    set_en(3'b000);
    ticks(20);
    set_en(3'b100);
    ticks(8);
    rd(8'hFF, v); check("R7 prescaler restarts", v, 8'd0);
    set_en(3'b000);
  endtask

  task automatic t_write_clear;
    logic [7:0] v;
    wr(8'hFC, 8'd1); set_en(3'b100);
    ticks(48);
    wr(8'hFF, 8'hA5);
    rd(8'hFF, v); check("R6 write clears counter", v, 8'd0);
    set_en(3'b000);
  endtask

  task automatic t_period_change;
    logic [7:0] v;
    wr(8'hFC, 8'd4); set_en(3'b100);
    ticks(32);
    wr(8'hFC, 8'd2);
    ticks(16);
    rd(8'hFF, v); check("R9 stage past new period wraps", v, 8'd1);
    wr(8'hFC, 8'd2);
    ticks(32);
    rd(8'hFF, v); check("R9 new period governs", v, 8'd1);
    set_en(3'b000);
  endtask

  task automatic t_coincident;
    logic [7:0] v;
    wr(8'hFC, 8'd1); set_en(3'b100);
    ticks(31);
    @(negedge clk); base_tick = 1'b1; addr = 8'hFF; rd_en = 1'b1;
    @(negedge clk); base_tick = 1'b0; rd_en = 1'b0;
    check("R10 read returns pre-increment", rdata, 8'd1);
    rd(8'hFF, v); check("R10 counter ends at zero", v, 8'd0);
    set_en(3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fast();
    t_slow();
    t_zero_period();
    t_wrap();
    t_enable();
    t_write_clear();
    t_period_change();
    t_coincident();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule